// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block watches a free-running time-base value supplied from outside and turns the rising transition of one selected bit of it into a periodic watchdog event. Two control bits choose which of four time-base bit positions gives the period. Each event moves a two-bit escalation state, held in the top two bits of a status register, one step further. The first event raises a warning flag. The second raises the interrupt status bit. A third event, if software has still not responded, produces a one-cycle reset request.

Software keeps the watchdog quiet by writing ones to the status bits it wants cleared. The control register is written as a whole word, and only its upper ten bits are stored. The interrupt output is the interrupt status bit gated by an enable bit in the control register. The reset generator that acts on the request lies outside this block.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, ctl_o, sts_o, irq_o and rst_req_o are all zero.
- R2: A control write (ctl_we_i) stores wdata_i ANDed with 0xFFC00000, so bits 31:22 are kept and bits 21:0 read as zero.
- R3: ctl_o[31:30] = k selects time-base bit TAPk (defaults TAP0..TAP3 = 1, 2, 3, 4). An event occurs in a cycle in which the selected bit is 1 and the bit that was selected in the previous cycle was 0 in that previous cycle.
- R4: An event with sts_o[31:30] equal to 00 or 01 sets sts_o[31] at the next clock edge.
- R5: An event with sts_o[31:30] equal to 10 sets sts_o[30] at the next clock edge.
- R6: An event with sts_o[31:30] equal to 11 drives rst_req_o high for exactly the following cycle and leaves the status unchanged. rst_req_o is low in every other cycle.
- R7: A status write (sts_we_i) clears every status bit where wdata_i[31:26] has a one. wdata_i[25:0] has no effect. With no write and no event, the status holds its value.
- R8: irq_o equals sts_o[30] AND ctl_o[27]. Clearing either bit drops it.
- R9: When a status write and an event fall in the same cycle, the clear is applied first and the event then advances the cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbase_i | input | TB_W | Time-base value |
| ctl_we_i | input | 1 | Control register write strobe |
| sts_we_i | input | 1 | Status register write-one-to-clear strobe |
| wdata_i | input | 32 | Write data for either register |
| ctl_o | output | 32 | Control register value |
| sts_o | output | 32 | Status register value |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
A software service, which is a write-one-to-clear on the status register, can land in the same cycle as a period event. The bench provokes this by issuing status writes on cycles where it also drives a rising transition of the selected time-base bit. It does this both in directed cases at each escalation state and at random. Each such cycle is judged against a bench model that applies the clear before the event. A change of period selection that coincides with a time-base transition is exercised in the same way.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [REG_W-1:0] CTL_KEEP_MASK = 32'hFFC0_0000;
  localparam logic [REG_W-1:0] STS_CLR_MASK  = 32'hFC00_0000;
  localparam int unsigned SEL_HI = 31;
  localparam int unsigned SEL_LO = 30;
  localparam int unsigned IRQ_EN_BIT = 27;
  localparam int unsigned WARN_BIT = 31;
  localparam int unsigned INT_BIT  = 30;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ODD   = 2'b01,
    ST_WARN  = 2'b10,
    ST_FIRED = 2'b11
  } esc_e;
endpackage

// File: rtl/wdt_tap_sel.sv
module wdt_tap_sel #(
  parameter int unsigned TB_W = 8,
  parameter int unsigned TAP0 = 1,
  parameter int unsigned TAP1 = 2,
  parameter int unsigned TAP2 = 3,
  parameter int unsigned TAP3 = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tbase_i,
  input  logic [1:0]      sel_i,
  output logic            evt_o
);
  localparam int unsigned N_TAP = 4;
  localparam int unsigned TAP_POS [N_TAP] = '{TAP0, TAP1, TAP2, TAP3};

  logic [N_TAP-1:0] taps;
  logic             sel_bit;
  logic             sel_q;

  for (genvar i = 0; i < N_TAP; i++) begin : g_tap
    assign taps[i] = tbase_i[TAP_POS[i]];
  end

  assign sel_bit = taps[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_bit;
  end

  assign evt_o = sel_bit & ~sel_q;

  AST_EVT_NEEDS_LOW_BEFORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o) else $error("event twice in a row"); // R3
endmodule

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_o <= '0;
    else if (we_i) ctl_o <= wdata_i & CTL_KEEP_MASK;
  end

  AST_CTL_WRITE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctl_o == ($past(wdata_i) & CTL_KEEP_MASK)) else $error("ctl write"); // R2
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_o)) else $error("ctl changed"); // R2
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sts_o,
  output logic             rst_req_o
);
  logic [REG_W-1:0] sts_q, sts_clr, sts_d;
  logic             req_q, req_d;
  esc_e             st_clr;

  always_comb begin
    sts_clr = we_i ? (sts_q & ~(wdata_i & STS_CLR_MASK)) : sts_q;
    st_clr  = esc_e'(sts_clr[WARN_BIT:INT_BIT]);
    sts_d   = sts_clr;
    req_d   = 1'b0;
    if (evt_i) begin
      unique case (st_clr)
        ST_IDLE, ST_ODD: sts_d[WARN_BIT] = 1'b1;
        ST_WARN:         sts_d[INT_BIT]  = 1'b1;
        ST_FIRED:        req_d           = 1'b1;
        default:         sts_d           = sts_clr;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      req_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      req_q <= req_d;
    end
  end

  assign sts_o     = sts_q;
  assign rst_req_o = req_q;

  AST_EVT_SETS_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> sts_o[WARN_BIT]) else $error("warn not set"); // R4
  AST_INT_AFTER_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[INT_BIT]) |-> $past(sts_o[WARN_BIT])) else $error("int early"); // R5
  AST_REQ_FROM_FIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ($past(sts_o[WARN_BIT] & sts_o[INT_BIT]) && $stable(sts_o[WARN_BIT:INT_BIT])))
    else $error("req without fired state"); // R6
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$past(rst_req_o)) else $error("req too long"); // R6
  AST_STS_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !we_i) |=> $stable(sts_o)) else $error("sts drifted"); // R7
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdt_pkg::*;
#(
  parameter int unsigned TB_W = 8,
  parameter int unsigned TAP0 = 1,
  parameter int unsigned TAP1 = 2,
  parameter int unsigned TAP2 = 3,
  parameter int unsigned TAP3 = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tbase_i,
  input  logic            ctl_we_i,
  input  logic            sts_we_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     ctl_o,
  output logic [31:0]     sts_o,
  output logic            irq_o,
  output logic            rst_req_o
);
  logic evt;

  wdt_ctl_reg u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctl_we_i),
    .wdata_i(wdata_i),
    .ctl_o  (ctl_o)
  );

  wdt_tap_sel #(
    .TB_W(TB_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
  ) u_tap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tbase_i(tbase_i),
    .sel_i  (ctl_o[SEL_HI:SEL_LO]),
    .evt_o  (evt)
  );

  wdt_escalate u_esc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .we_i     (sts_we_i),
    .wdata_i  (wdata_i),
    .sts_o    (sts_o),
    .rst_req_o(rst_req_o)
  );

  assign irq_o = sts_o[INT_BIT] & ctl_o[IRQ_EN_BIT];

  AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && wdata_i[INT_BIT] && !evt) |=> !irq_o) else $error("irq stuck"); // R8
  AST_SERVICE_THEN_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && wdata_i[WARN_BIT] && wdata_i[INT_BIT] && evt) |=>
      (sts_o[WARN_BIT:INT_BIT] == 2'b10 && !rst_req_o)) else $error("collision order"); // R9
endmodule

// File: tb/tb_wdog_two_stage.sv
`timescale 1ns/1ps
module tb_wdog_two_stage;
  localparam int TB_W = 8;
  localparam int TAPS [4] = '{1, 2, 3, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TB_W-1:0] tbase = '0;
  logic ctl_we = 1'b0, sts_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] ctl, sts;
  logic irq, rst_req;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_ctl = '0, m_sts = '0;
  logic m_prev = 1'b0, m_req = 1'b0;

  always #10 clk = ~clk;

  wdog_two_stage #(.TB_W(TB_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tbase_i(tbase), .ctl_we_i(ctl_we),
    .sts_we_i(sts_we), .wdata_i(wdata), .ctl_o(ctl), .sts_o(sts),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic sel_bit(input logic [31:0] c, input logic [TB_W-1:0] t);
    return t[TAPS[c[31:30]]];
  endfunction

  task automatic check_all();
    chk(ctl == m_ctl, "R2", ctl, m_ctl);
    chk(sts == m_sts, "R3/R4/R5/R7/R9 sts", sts, m_sts);
    chk(rst_req == m_req, "R6 rst_req", {31'b0, rst_req}, {31'b0, m_req});
    chk(irq == (m_sts[30] & m_ctl[27]), "R8 irq", {31'b0, irq}, {31'b0, m_sts[30] & m_ctl[27]});
  endtask

  // one cycle: drive after negedge, model the posedge, compare at the next negedge
  task automatic step(input bit cwe, input bit swe, input logic [31:0] wd, input logic [TB_W-1:0] tb);
    logic sb, ev;
    logic [31:0] cl;
    ctl_we = cwe; sts_we = swe; wdata = wd; tbase = tb;
    sb = sel_bit(m_ctl, tb);
    ev = sb & ~m_prev;
    m_prev = sb;
    cl = swe ? (m_sts & ~(wd & 32'hFC00_0000)) : m_sts;
    m_req = 1'b0;
    if (ev) begin
      case (cl[31:30])
        2'b00, 2'b01: cl[31] = 1'b1;
        2'b10:        cl[30] = 1'b1;
        default:      m_req = 1'b1;
      endcase
    end
    m_sts = cl;
    if (cwe) m_ctl = wd & 32'hFFC0_0000;
    @(negedge clk);
    check_all();
  endtask

  task automatic pulse(input int tap);
    step(0, 0, 32'h0, '0);
    step(0, 0, 32'h0, TB_W'(1) << tap);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl == 0 && sts == 0 && !irq && !rst_req, "R1 reset", sts, 32'h0);

    // R2 masking
    step(1, 0, 32'hFFFF_FFFF, '0);
    chk(ctl == 32'hFFC0_0000, "R2 ctl mask", ctl, 32'hFFC0_0000);
    // select tap0, irq enabled
    step(1, 0, 32'h0800_0000, '0);
    pulse(TAPS[0]);
    chk(sts[31:30] == 2'b10, "R4 first event", sts, 32'h8000_0000);
    pulse(TAPS[0]);
    chk(sts[31:30] == 2'b11 && irq, "R5 second event", sts, 32'hC000_0000);
    pulse(TAPS[0]);
    chk(rst_req && sts[31:30] == 2'b11, "R6 third event", {31'b0, rst_req}, 32'h1);
    step(0, 0, 32'h0, '0);
    chk(!rst_req, "R6 one cycle", {31'b0, rst_req}, 32'h0);
    // R8: drop enable
    step(1, 0, 32'h0, '0);
    chk(!irq, "R8 enable gate", {31'b0, irq}, 32'h0);
    // R7: low data bits ignored, clear int only
    step(0, 1, 32'h03FF_FFFF, '0);
    chk(sts[31:30] == 2'b11, "R7 low bits ignored", sts, 32'hC000_0000);
    step(0, 1, 32'h4000_0000, '0);
    chk(sts[31:30] == 2'b10, "R7 clear int", sts, 32'h8000_0000);
    // R3: tap 2 selected, tap0 toggle ignored
    step(1, 0, 32'h8800_0000, '0);
    step(0, 1, 32'hC000_0000, TB_W'(1) << TAPS[0]);
    chk(sts == 0, "R3 unselected tap", sts, 32'h0);
    step(0, 0, 32'h0, TB_W'(1) << TAPS[2]);
    chk(sts[31:30] == 2'b10, "R3 selected tap", sts, 32'h8000_0000);
    // R9: service and event in same cycle from state 10 and 11
    step(0, 0, 32'h0, '0);
    step(0, 1, 32'hC000_0000, TB_W'(1) << TAPS[2]);
    chk(sts[31:30] == 2'b10 && !rst_req, "R9 clear then event", sts, 32'h8000_0000);
    pulse(TAPS[2]);
    step(0, 0, 32'h0, '0);
    step(0, 1, 32'h4000_0000, TB_W'(1) << TAPS[2]);
    chk(sts[31:30] == 2'b11 && !rst_req, "R9 int cleared then re-set", sts, 32'hC000_0000);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic cwe, swe;
      logic [31:0] wd;
      cwe = ($urandom % 16) == 0;
      swe = ($urandom % 6) == 0;
      wd  = $urandom;
      step(cwe, swe, wd, TB_W'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule